// File: doc/BRIEF.md
# Multi-rail power-up sequencer controller

This block decides when six regulator enable outputs switch on and off: one switching converter (rail 0) and five linear regulators (rails 1 to 5). Each rail holds a 3-bit slot code. The sequence time is counted in slot periods of `TICKS_PER_SLOT` base ticks, default 128, and one base tick is one clock cycle with `tick_i` high. A rail turns on once `code + 1` whole slot periods have passed since the sequence started. Rails that share a code therefore turn on at the same tick.

Raising the hardware enable starts power-up. Lowering it walks the same schedule back down, so the rail with the highest code is the first to turn off. If the enable changes mid-sequence, the sequencer turns around at its current period count. Once the sequence is complete, software can switch single rails through an enable register and choose per-rail output discharge through a discharge register. It can also move the slot codes, all through a simple write port. Thermal shutdown and undervoltage lockout remove every rail at once without sequencing. Undervoltage lockout also returns all registers to their factory values.

Top module: `pwrseq_ctrl`

## Requirements
- R1: Out of reset, `rail_en_o` is all zero, `dis_o` is all ones and `busy_o` is low. The slot codes reset to 0, 1, 3, 4, 5, 6 for rails 0 to 5. The enable and discharge registers reset to all ones.
- R2: If power-up starts with no register writes, rails 0 to 5 turn on after 1, 2, 4, 5, 6 and 7 slot periods.
- R3: The clock edge that sees `hw_en_i` high in the off state starts the sequence at period count 0. Each group of `TICKS_PER_SLOT` base ticks adds one to the count. Rail r is on exactly when the count is greater than its code, so equal codes switch together. Clock cycles without `tick_i` do not advance the count.
- R4: `busy_o` is high from the start edge until the count reaches 8 (2^3). The sequencer is then in the on state and `busy_o` is low.
- R5: While `hw_en_i` is low after power-up, each slot period lowers the count by one. Rail r turns off when the count falls to its code. At count 0 the block is off and `busy_o` is low. A turn-down that begins at count 0 ends on the next clock edge.
- R6: A change of `hw_en_i` during a sequence reverses direction at the current count. The partial slot period starts again from zero.
- R7: In the on state, writing address 6 sets the enable register, bit r being rail r. Each rail output then follows its bit from the next cycle. Writes to address 6 outside the on state are ignored. The register is loaded with all ones whenever a sequence starts from off, and rails left off by software stay off during a turn-down.
- R8: `dis_o` is all ones outside the on state. In the on state it equals the discharge register, written at address 7 with bit r for rail r.
- R9: Writing address r (0 to 5) sets rail r's slot code from data bits [2:0] while the block is off or on. Writes made while `busy_o` is high are ignored.
- R10: When `uvlo_i` is high, all rail enables drop in the same cycle. All state and registers are held at their reset values, and a new sequence starts on the first edge after release if `hw_en_i` is high.
- R11: When `therm_i` is high, the next edge turns every rail off and returns the sequencer to off, with `busy_o` low and `dis_o` all ones. The registers keep their values. After `therm_i` clears with `hw_en_i` high, power-up restarts from count 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| uvlo_i | input | 1 | Undervoltage lockout, holds the block in reset |
| therm_i | input | 1 | Thermal shutdown request |
| hw_en_i | input | 1 | Hardware enable: high powers up, low powers down |
| tick_i | input | 1 | Base tick strobe, one clock wide per tick |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 3 | Write address: 0-5 slot codes, 6 enable, 7 discharge |
| wr_data_i | input | 6 | Write data |
| rail_en_o | output | 6 | Regulator enables, bit r for rail r |
| dis_o | output | 6 | Output discharge controls, bit r for rail r |
| busy_o | output | 1 | High while a power-up or turn-down sequence runs |

## Verification
The properties assume that the enable register changes only through an explicit write. Under that assumption, a rail can rise only on a base tick while powering up, or when a sequence starts. They also assume that `tick_i` is a single-cycle strobe sampled on the clock, and that `uvlo_i` and `therm_i` are already synchronous. The stimulus drives every input at the falling clock edge. It holds `tick_i` high for exactly one cycle per tick, and it writes registers only in cycles with no tick, so no rail change is tied to a write in an unintended way.

// File: rtl/pwrseq_pkg.sv
package pwrseq_pkg;

    typedef enum logic [1:0] {
        SEQ_OFF  = 2'd0,
        SEQ_UP   = 2'd1,
        SEQ_ON   = 2'd2,
        SEQ_DOWN = 2'd3
    } seq_state_e;

endpackage

// File: rtl/pwrseq_timer.sv
module pwrseq_timer
    import pwrseq_pkg::*;
#(
    parameter int SLOT_W         = 3,
    parameter int TICKS_PER_SLOT = 128
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              clr_i,
    input  logic              hw_en_i,
    input  logic              therm_i,
    input  logic              tick_i,
    output seq_state_e        state_o,
    output logic [SLOT_W:0]   per_o,
    output logic              start_o
);

    localparam int SUB_W = $clog2(TICKS_PER_SLOT);
    localparam int PER_W = SLOT_W + 1;
    localparam logic [SUB_W-1:0] SUB_LAST = SUB_W'(TICKS_PER_SLOT - 1);
    localparam logic [PER_W-1:0] PER_LAST = PER_W'((2 ** SLOT_W) - 1);
    localparam logic [PER_W-1:0] PER_ONE  = PER_W'(1);

    typedef struct packed {
        seq_state_e       st;
        logic [SUB_W-1:0] sub;
        logic [PER_W-1:0] per;
    } tmr_t;

    localparam tmr_t TMR_RST = '{st: SEQ_OFF, sub: '0, per: '0};

    tmr_t tmr_d, tmr_q;
    logic wrap;

    assign wrap = tick_i && (tmr_q.sub == SUB_LAST);

    always_comb begin
        tmr_d   = tmr_q;
        start_o = 1'b0;
        if (therm_i) begin
            tmr_d = TMR_RST;
        end else begin
            unique case (tmr_q.st)
                SEQ_OFF: begin
                    if (hw_en_i) begin
                        tmr_d.st  = SEQ_UP;
                        tmr_d.sub = '0;
                        tmr_d.per = '0;
                        start_o   = 1'b1;
                    end
                end
                SEQ_UP: begin
                    if (!hw_en_i) begin
                        tmr_d.st  = SEQ_DOWN;
                        tmr_d.sub = '0;
                    end else if (tick_i) begin
                        tmr_d.sub = wrap ? '0 : tmr_q.sub + 1'b1;
                        if (wrap) begin
                            tmr_d.per = tmr_q.per + 1'b1;
                            if (tmr_q.per == PER_LAST) begin
                                tmr_d.st = SEQ_ON;
                            end
                        end
                    end
                end
                SEQ_ON: begin
                    if (!hw_en_i) begin
                        tmr_d.st  = SEQ_DOWN;
                        tmr_d.sub = '0;
                    end
                end
                SEQ_DOWN: begin
                    if (hw_en_i) begin
                        tmr_d.st  = SEQ_UP;
                        tmr_d.sub = '0;
                    end else if (tmr_q.per == '0) begin
                        tmr_d.st = SEQ_OFF;
                    end else if (tick_i) begin
                        tmr_d.sub = wrap ? '0 : tmr_q.sub + 1'b1;
                        if (wrap) begin
                            tmr_d.per = tmr_q.per - 1'b1;
                            if (tmr_q.per == PER_ONE) begin
                                tmr_d.st = SEQ_OFF;
                            end
                        end
                    end
                end
                default: tmr_d = TMR_RST;
            endcase
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            tmr_q <= TMR_RST;
        end else if (clr_i) begin
            tmr_q <= TMR_RST;
        end else begin
            tmr_q <= tmr_d;
        end
    end

    assign state_o = tmr_q.st;
    assign per_o   = tmr_q.per;

endmodule

// File: rtl/pwrseq_cfg.sv
module pwrseq_cfg #(
    parameter int NUM_RAILS = 6,
    parameter int SLOT_W    = 3,
    parameter logic [NUM_RAILS*SLOT_W-1:0] DEFAULT_CODES = 18'o654310
) (
    input  logic                                   clk_i,
    input  logic                                   rst_ni,
    input  logic                                   clr_i,
    input  logic                                   wr_en_i,
    input  logic [$clog2(NUM_RAILS+2)-1:0]         wr_addr_i,
    input  logic [NUM_RAILS-1:0]                   wr_data_i,
    input  logic                                   start_i,
    input  logic                                   on_i,
    input  logic                                   busy_i,
    output logic [NUM_RAILS-1:0][SLOT_W-1:0]       codes_o,
    output logic [NUM_RAILS-1:0]                   en_mask_o,
    output logic [NUM_RAILS-1:0]                   dis_reg_o
);

    localparam int ADDR_W = $clog2(NUM_RAILS + 2);
    localparam logic [ADDR_W-1:0] EN_ADDR  = ADDR_W'(NUM_RAILS);
    localparam logic [ADDR_W-1:0] DIS_ADDR = ADDR_W'(NUM_RAILS + 1);

    typedef struct packed {
        logic [NUM_RAILS-1:0][SLOT_W-1:0] codes;
        logic [NUM_RAILS-1:0]             en;
        logic [NUM_RAILS-1:0]             dis;
    } cfg_t;

    localparam cfg_t CFG_RST = '{codes: DEFAULT_CODES, en: '1, dis: '1};

    cfg_t cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        if (start_i) begin
            cfg_d.en = '1;
        end
        if (wr_en_i) begin
            if (wr_addr_i == EN_ADDR) begin
                if (on_i) begin
                    cfg_d.en = wr_data_i;
                end
            end else if (wr_addr_i == DIS_ADDR) begin
                cfg_d.dis = wr_data_i;
            end else if (!busy_i) begin
                for (int r = 0; r < NUM_RAILS; r++) begin
                    if (wr_addr_i == ADDR_W'(r)) begin
                        cfg_d.codes[r] = wr_data_i[SLOT_W-1:0];
                    end
                end
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            cfg_q <= CFG_RST;
        end else if (clr_i) begin
            cfg_q <= CFG_RST;
        end else begin
            cfg_q <= cfg_d;
        end
    end

    assign codes_o   = cfg_q.codes;
    assign en_mask_o = cfg_q.en;
    assign dis_reg_o = cfg_q.dis;

endmodule

// File: rtl/pwrseq_rail_gate.sv
module pwrseq_rail_gate #(
    parameter int NUM_RAILS = 6,
    parameter int SLOT_W    = 3
) (
    input  logic [SLOT_W:0]                   per_i,
    input  logic [NUM_RAILS-1:0][SLOT_W-1:0]  codes_i,
    input  logic [NUM_RAILS-1:0]              en_mask_i,
    input  logic [NUM_RAILS-1:0]              dis_reg_i,
    input  logic                              on_i,
    input  logic                              kill_i,
    output logic [NUM_RAILS-1:0]              rail_en_o,
    output logic [NUM_RAILS-1:0]              dis_o
);

    for (genvar r = 0; r < NUM_RAILS; r++) begin : g_rail
        logic slot_reached;
        assign slot_reached = per_i > {1'b0, codes_i[r]};
        assign rail_en_o[r] = !kill_i && en_mask_i[r] && slot_reached;
        assign dis_o[r]     = kill_i || !on_i || dis_reg_i[r];
    end

endmodule

// File: rtl/pwrseq_ctrl.sv
module pwrseq_ctrl
    import pwrseq_pkg::*;
#(
    parameter int NUM_RAILS      = 6,
    parameter int SLOT_W         = 3,
    parameter int TICKS_PER_SLOT = 128,
    parameter logic [NUM_RAILS*SLOT_W-1:0] DEFAULT_CODES = 18'o654310
) (
    input  logic                              clk_i,
    input  logic                              rst_ni,
    input  logic                              uvlo_i,
    input  logic                              therm_i,
    input  logic                              hw_en_i,
    input  logic                              tick_i,
    input  logic                              wr_en_i,
    input  logic [$clog2(NUM_RAILS+2)-1:0]    wr_addr_i,
    input  logic [NUM_RAILS-1:0]              wr_data_i,
    output logic [NUM_RAILS-1:0]              rail_en_o,
    output logic [NUM_RAILS-1:0]              dis_o,
    output logic                              busy_o
);

    seq_state_e                        state;
    logic [SLOT_W:0]                   per;
    logic                              start;
    logic                              seq_on;
    logic [NUM_RAILS-1:0][SLOT_W-1:0]  codes;
    logic [NUM_RAILS-1:0]              en_mask;
    logic [NUM_RAILS-1:0]              dis_reg;

    assign seq_on = (state == SEQ_ON);
    assign busy_o = (state == SEQ_UP) || (state == SEQ_DOWN);

    pwrseq_timer #(
        .SLOT_W         (SLOT_W),
        .TICKS_PER_SLOT (TICKS_PER_SLOT)
    ) timer_i (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .clr_i   (uvlo_i),
        .hw_en_i (hw_en_i),
        .therm_i (therm_i),
        .tick_i  (tick_i),
        .state_o (state),
        .per_o   (per),
        .start_o (start)
    );

    pwrseq_cfg #(
        .NUM_RAILS     (NUM_RAILS),
        .SLOT_W        (SLOT_W),
        .DEFAULT_CODES (DEFAULT_CODES)
    ) cfg_i (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .clr_i     (uvlo_i),
        .wr_en_i   (wr_en_i),
        .wr_addr_i (wr_addr_i),
        .wr_data_i (wr_data_i),
        .start_i   (start),
        .on_i      (seq_on),
        .busy_i    (busy_o),
        .codes_o   (codes),
        .en_mask_o (en_mask),
        .dis_reg_o (dis_reg)
    );

    pwrseq_rail_gate #(
        .NUM_RAILS (NUM_RAILS),
        .SLOT_W    (SLOT_W)
    ) gate_i (
        .per_i     (per),
        .codes_i   (codes),
        .en_mask_i (en_mask),
        .dis_reg_i (dis_reg),
        .on_i      (seq_on),
        .kill_i    (uvlo_i),
        .rail_en_o (rail_en_o),
        .dis_o     (dis_o)
    );

endmodule

// File: rtl/pwrseq_ctrl_chk.sv
module pwrseq_ctrl_chk #(
    parameter int NUM_RAILS = 6
) (
    input logic                 clk_i,
    input logic                 rst_ni,
    input logic                 uvlo_i,
    input logic                 therm_i,
    input logic                 hw_en_i,
    input logic                 tick_i,
    input logic                 wr_en_i,
    input logic [NUM_RAILS-1:0] rail_en_o,
    input logic [NUM_RAILS-1:0] dis_o,
    input logic                 busy_o
);

    // R10: undervoltage removes every enable in the same cycle
    a_r10_uvlo_drop: assert property (@(posedge clk_i) disable iff (!rst_ni)
        uvlo_i |-> (rail_en_o == '0));

    // R11: thermal shutdown leaves no rail on after the next edge
    a_r11_therm_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
        therm_i |=> (rail_en_o == '0));

    // R8: discharge is forced for every rail while a sequence runs
    a_r8_seq_discharge: assert property (@(posedge clk_i) disable iff (!rst_ni)
        busy_o |-> (&dis_o));

    // R5: with the enable low and no write, no rail can switch on
    a_r5_no_rise_down: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!hw_en_i && !wr_en_i) |=> ((rail_en_o & ~$past(rail_en_o)) == '0));

    // R3: without a base tick, the schedule cannot turn a rail on
    a_r3_no_tick_no_rise: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (hw_en_i && !tick_i && !wr_en_i) |=> ((rail_en_o & ~$past(rail_en_o)) == '0));

endmodule

bind pwrseq_ctrl pwrseq_ctrl_chk #(
    .NUM_RAILS (NUM_RAILS)
) chk_i (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .uvlo_i    (uvlo_i),
    .therm_i   (therm_i),
    .hw_en_i   (hw_en_i),
    .tick_i    (tick_i),
    .wr_en_i   (wr_en_i),
    .rail_en_o (rail_en_o),
    .dis_o     (dis_o),
    .busy_o    (busy_o)
);

// File: tb/pwrseq_ctrl_tb_top.sv
module pwrseq_ctrl_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int T          = 4;
    localparam int FULL       = 8;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       uvlo, therm, hw_en, tick, wr_en;
    logic [2:0] wr_addr;
    logic [5:0] wr_data;
    logic [5:0] rail_en, dis;
    logic       busy;

    int  n_chk  = 0;
    int  n_fail = 0;
    bit  done   = 0;
    int  codes[6];
    logic [5:0] exp_dis = 6'h3F;

    always #(CLK_PERIOD/2) clk = ~clk;

    pwrseq_ctrl #(
        .TICKS_PER_SLOT (T)
    ) dut_i (
        .clk_i     (clk),
        .rst_ni    (rst_n),
        .uvlo_i    (uvlo),
        .therm_i   (therm),
        .hw_en_i   (hw_en),
        .tick_i    (tick),
        .wr_en_i   (wr_en),
        .wr_addr_i (wr_addr),
        .wr_data_i (wr_data),
        .rail_en_o (rail_en),
        .dis_o     (dis),
        .busy_o    (busy)
    );

    task automatic check(string tag, string what, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: got %0h expected %0h at %0t", tag, what, act, exp, $time);
        end
    endtask

    function automatic logic [5:0] exp_rails(int per, logic [5:0] mask);
        logic [5:0] v;
        for (int r = 0; r < 6; r++) v[r] = mask[r] && (per > codes[r]);
        return v;
    endfunction

    task automatic set_hw(logic v);
        hw_en = v;
        @(negedge clk);
    endtask

    task automatic do_tick();
        tick = 1'b1;
        @(negedge clk);
        tick = 1'b0;
    endtask

    task automatic ticks(int n);
        for (int i = 0; i < n; i++) do_tick();
    endtask

    task automatic reg_write(logic [2:0] a, logic [5:0] d);
        wr_en   = 1'b1;
        wr_addr = a;
        wr_data = d;
        @(negedge clk);
        wr_en   = 1'b0;
    endtask

    task automatic load_codes();
        for (int r = 0; r < 6; r++) reg_write(3'(r), 6'(codes[r]));
    endtask

    // Caller has already produced the start edge; count is 0 here.
    task automatic run_up(string tag, logic [5:0] mask);
        check(tag, "rails at start", 32'(rail_en), 32'(6'h0));
        check(tag, "busy at start", 32'(busy), 32'(1));
        check(tag, "discharge while busy", 32'(dis), 32'(6'h3F));
        for (int n = 1; n <= FULL * T; n++) begin
            int per;
            do_tick();
            per = n / T;
            check(tag, "rails rising", 32'(rail_en), 32'(exp_rails(per, mask)));
            check("R4", "busy rising", 32'(busy), 32'(per < FULL));
        end
        check("R8", "discharge in on state", 32'(dis), 32'(exp_dis));
    endtask

    task automatic run_down(string tag, logic [5:0] mask);
        set_hw(1'b0);
        check(tag, "rails at turn-down", 32'(rail_en), 32'(exp_rails(FULL, mask)));
        check(tag, "busy at turn-down", 32'(busy), 32'(1));
        for (int k = 1; k <= FULL * T; k++) begin
            int per;
            do_tick();
            per = FULL - k / T;
            check(tag, "rails falling", 32'(rail_en), 32'(exp_rails(per, mask)));
            check(tag, "busy falling", 32'(busy), 32'(per > 0));
        end
        check("R8", "discharge when off", 32'(dis), 32'(6'h3F));
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: run did not complete, got timeout expected completion");
        finish_run();
    end

    initial begin
        rst_n = 1'b0; uvlo = 1'b0; therm = 1'b0; hw_en = 1'b0; tick = 1'b0;
        wr_en = 1'b0; wr_addr = '0; wr_data = '0;
        codes = '{0, 1, 3, 4, 5, 6};
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        check("R1", "rails after reset", 32'(rail_en), 32'(0));
        check("R1", "discharge after reset", 32'(dis), 32'(6'h3F));
        check("R1", "busy after reset", 32'(busy), 32'(0));

        // R2 with R9 and R7: writes made while busy are ignored, default schedule applies
        set_hw(1'b1);
        reg_write(3'd0, 6'd7);
        reg_write(3'd6, 6'h00);
        ticks(0);
        run_up("R2", 6'h3F);

        // R7 and R8 in the on state
        reg_write(3'd6, 6'h2A);
        check("R7", "enable register drives rails", 32'(rail_en), 32'(6'h2A));
        reg_write(3'd7, 6'h15);
        exp_dis = 6'h15;
        check("R8", "discharge register in on state", 32'(dis), 32'(6'h15));
        run_down("R5", 6'h2A);

        // R6: reversal during power-up restarts the partial period
        set_hw(1'b1);
        ticks(2 * T + 1);
        check("R6", "rails at count 2", 32'(rail_en), 32'(6'h03));
        set_hw(1'b0);
        check("R6", "rails after reversal", 32'(rail_en), 32'(6'h03));
        check("R6", "busy after reversal", 32'(busy), 32'(1));
        ticks(T - 1);
        check("R6", "count held through partial period", 32'(rail_en), 32'(6'h03));
        do_tick();
        check("R6", "rails at count 1", 32'(rail_en), 32'(6'h01));
        ticks(T);
        check("R6", "rails off at count 0", 32'(rail_en), 32'(6'h00));
        check("R6", "busy clear at count 0", 32'(busy), 32'(0));

        // R6: reversal during turn-down; R7 mask reloaded on start from off
        set_hw(1'b1);
        run_up("R7", 6'h3F);
        set_hw(1'b0);
        ticks(T);
        check("R6", "rails at count 7", 32'(rail_en), 32'(6'h3F));
        ticks(2 * T);
        check("R6", "rails at count 5", 32'(rail_en), 32'(6'h0F));
        set_hw(1'b1);
        check("R6", "rails after up-reversal", 32'(rail_en), 32'(6'h0F));
        check("R6", "busy after up-reversal", 32'(busy), 32'(1));
        ticks(T);
        check("R6", "rails at count 6", 32'(rail_en), 32'(6'h1F));
        ticks(T);
        check("R6", "rails at count 7 rising", 32'(rail_en), 32'(6'h3F));
        check("R6", "busy at count 7", 32'(busy), 32'(1));
        ticks(T);
        check("R4", "busy clear in on state", 32'(busy), 32'(0));
        run_down("R5", 6'h3F);

        // R5: a turn-down from count 0 ends on the next edge
        set_hw(1'b1);
        do_tick();
        set_hw(1'b0);
        check("R5", "busy during empty turn-down", 32'(busy), 32'(1));
        @(negedge clk);
        check("R5", "busy after empty turn-down", 32'(busy), 32'(0));
        check("R5", "rails after empty turn-down", 32'(rail_en), 32'(0));

        // R3 and R9: sweep codes, every rail sees every code
        for (int c = 0; c < 8; c++) begin
            for (int r = 0; r < 6; r++) codes[r] = (c + 3 * r) % 8;
            load_codes();
            set_hw(1'b1);
            run_up("R3", 6'h3F);
            run_down("R5", 6'h3F);
        end
        // R3: rails sharing a code switch on the same tick
        for (int c = 2; c < 9; c += 5) begin
            for (int r = 0; r < 6; r++) codes[r] = c % 8;
            load_codes();
            set_hw(1'b1);
            run_up("R3", 6'h3F);
            run_down("R5", 6'h3F);
        end

        // R11: thermal shutdown keeps registers and restarts
        for (int r = 0; r < 6; r++) codes[r] = (5 + 3 * r) % 8;
        load_codes();
        set_hw(1'b1);
        run_up("R11", 6'h3F);
        therm = 1'b1;
        @(negedge clk);
        check("R11", "rails in thermal shutdown", 32'(rail_en), 32'(0));
        check("R11", "busy in thermal shutdown", 32'(busy), 32'(0));
        check("R11", "discharge in thermal shutdown", 32'(dis), 32'(6'h3F));
        repeat (3) @(negedge clk);
        check("R11", "rails held off", 32'(rail_en), 32'(0));
        therm = 1'b0;
        @(negedge clk);
        run_up("R11", 6'h3F);

        // R10: undervoltage drops rails at once and restores defaults
        uvlo = 1'b1;
        #1;
        check("R10", "rails drop in same cycle", 32'(rail_en), 32'(0));
        @(negedge clk);
        check("R10", "busy in lockout", 32'(busy), 32'(0));
        check("R10", "discharge in lockout", 32'(dis), 32'(6'h3F));
        uvlo = 1'b0;
        @(negedge clk);
        codes = '{0, 1, 3, 4, 5, 6};
        exp_dis = 6'h3F;
        run_up("R10", 6'h3F);
        run_down("R5", 6'h3F);

        finish_run();
    end

endmodule